// File: doc/BRIEF.md
# Accumulator Adder with Link Rotator

This block is the arithmetic core of a 12-bit accumulator machine. Each cycle it forms two adder operands from a shared bus value and the accumulator, adds them in a 12-bit ripple-carry adder, and derives a new link bit. The new link bit is a selected link source, flipped whenever the adder carries out. The 12-bit sum and the new link together make a 13-bit word. That word can be rotated one or two places in either direction, or passed straight through.

Decode logic outside the block drives four small control fields: operand A source, operand B source, link source, and a one-hot rotate select. The result is registered, with bit 12 holding the new link and bits 11..0 holding the new accumulator value. Write-back of that result into the architectural registers happens elsewhere.

Top module: `alu_link_rot`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge sets `res_o` to zero, whatever the other inputs are.
- R2: Operand A follows `asel_i`: 0 gives `bus_i`, 1 gives zero, 2 gives `bus_i & acc_i`, 3 gives `bus_i | acc_i`.
- R3: Operand B follows `bsel_i`: 0 gives `acc_i`, 1 gives `~acc_i`, 2 gives zero, 3 gives all ones (octal 7777).
- R4: With no rotation, `res_o[11:0]` is (A + B) mod 4096. The adder carry-out is bit 12 of the full 13-bit sum A + B.
- R5: The link source follows `lsel_i`: 0 gives `link_i`, 1 gives `~link_i`, 2 gives 0, 3 gives 1. Before rotation, bit 12 of the word is that source XOR the adder carry-out.
- R6: `rot_i` bit 0 selects rotate left by one and bit 1 selects rotate left by two. In a left rotation by one, result bit 0 takes word bit 12 and every other bit i takes word bit i-1.
- R7: `rot_i` bit 2 selects rotate right by one and bit 3 selects rotate right by two. In a right rotation by one, result bit 12 takes word bit 0 and every other bit i takes word bit i+1.
- R8: When `rot_i` is zero, the 13-bit word passes through unchanged.
- R9: When more than one bit of `rot_i` is set, the word passes through unchanged.
- R10: `res_o` shows the result for the inputs present at the previous rising edge, so the latency is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_i | input | 12 | Shared bus value |
| acc_i | input | 12 | Accumulator value |
| link_i | input | 1 | Current link bit |
| asel_i | input | 2 | Operand A source select |
| bsel_i | input | 2 | Operand B source select |
| lsel_i | input | 2 | Link source select |
| rot_i | input | 4 | Rotate select: bit0 L1, bit1 L2, bit2 R1, bit3 R2 |
| res_o | output | 13 | Registered result: bit 12 new link, bits 11..0 value |

## Verification
Operand selection is tested by sweeping each A code against a zero B, and each B code against a zero A. In each sweep the bus and accumulator values have bits that differ, so that AND, OR, complement and the constants all give distinct results. Sums that overflow exactly at 7777 + 1, sums that stay just below the overflow point, and random pairs separate a correct carry chain from a dropped or misrouted carry. The same cases, crossed with every link code, show whether the carry inverts the link. For the rotator, single-bit and asymmetric patterns are run under each one-hot select, under zero and under multi-bit selects. These patterns tell the two directions and the one- and two-place distances apart, and show whether the wrap-around bit lands in the right position.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {ASEL_BUS = 2'd0, ASEL_ZERO = 2'd1, ASEL_AND = 2'd2, ASEL_OR = 2'd3} asel_e;
  typedef enum logic [1:0] {BSEL_ACC = 2'd0, BSEL_NACC = 2'd1, BSEL_ZERO = 2'd2, BSEL_ONES = 2'd3} bsel_e;
  typedef enum logic [1:0] {LSEL_LINK = 2'd0, LSEL_NLINK = 2'd1, LSEL_ZERO = 2'd2, LSEL_ONE = 2'd3} lsel_e;
  localparam int ROT_W = 4;
  localparam int ROT_L1 = 0;
  localparam int ROT_L2 = 1;
  localparam int ROT_R1 = 2;
  localparam int ROT_R2 = 3;
endpackage

// File: rtl/alu_opsel.sv
module alu_opsel
  import alu_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0] bus_i,
  input  logic [W-1:0] acc_i,
  input  logic [1:0]   asel_i,
  input  logic [1:0]   bsel_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  always_comb begin
    unique case (asel_e'(asel_i))
      ASEL_BUS:  a_o = bus_i;
      ASEL_ZERO: a_o = '0;
      ASEL_AND:  a_o = bus_i & acc_i;
      ASEL_OR:   a_o = bus_i | acc_i;
      default:   a_o = '0;
    endcase
  end

  always_comb begin
    unique case (bsel_e'(bsel_i))
      BSEL_ACC:  b_o = acc_i;
      BSEL_NACC: b_o = ~acc_i;
      BSEL_ZERO: b_o = '0;
      BSEL_ONES: b_o = '1;
      default:   b_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_ripple_add.sv
module alu_ripple_add #(
  parameter int W = 12
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < W; g++) begin : g_fa
    logic half;
    assign half       = a_i[g] ^ b_i[g];
    assign sum_o[g]   = half ^ carry[g];
    assign carry[g+1] = (a_i[g] & b_i[g]) | (carry[g] & half);
  end

  assign cout_o = carry[W];
endmodule

// File: rtl/alu_rotator.sv
module alu_rotator
  import alu_pkg::*;
#(
  parameter int N = 13
) (
  input  logic [N-1:0]     d_i,
  input  logic [ROT_W-1:0] rot_i,
  output logic [N-1:0]     q_o
);
  logic single, rl1, rl2, rr1, rr2, pass;

  assign single = ($countones(rot_i) == 1);
  assign rl1    = single & rot_i[ROT_L1];
  assign rl2    = single & rot_i[ROT_L2];
  assign rr1    = single & rot_i[ROT_R1];
  assign rr2    = single & rot_i[ROT_R2];
  assign pass   = ~single;

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int IL1 = (i + N - 1) % N;
    localparam int IL2 = (i + N - 2) % N;
    localparam int IR1 = (i + 1) % N;
    localparam int IR2 = (i + 2) % N;
    assign q_o[i] = (rl1  & d_i[IL1]) | (rl2 & d_i[IL2]) |
                    (rr1  & d_i[IR1]) | (rr2 & d_i[IR2]) |
                    (pass & d_i[i]);
  end
endmodule

// File: rtl/alu_link_rot.sv
module alu_link_rot
  import alu_pkg::*;
#(
  parameter int W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     bus_i,
  input  logic [W-1:0]     acc_i,
  input  logic             link_i,
  input  logic [1:0]       asel_i,
  input  logic [1:0]       bsel_i,
  input  logic [1:0]       lsel_i,
  input  logic [ROT_W-1:0] rot_i,
  output logic [W:0]       res_o
);
  localparam int N = W + 1;

  logic [W-1:0] a_w, b_w, sum_w;
  logic         cout_w, lsrc_w;
  logic [N-1:0] pre_w, rot_w;

  alu_opsel #(.W(W)) u_opsel (
    .bus_i(bus_i), .acc_i(acc_i), .asel_i(asel_i), .bsel_i(bsel_i),
    .a_o(a_w), .b_o(b_w)
  );

  alu_ripple_add #(.W(W)) u_add (
    .a_i(a_w), .b_i(b_w), .sum_o(sum_w), .cout_o(cout_w)
  );

  always_comb begin
    unique case (lsel_e'(lsel_i))
      LSEL_LINK:  lsrc_w = link_i;
      LSEL_NLINK: lsrc_w = ~link_i;
      LSEL_ZERO:  lsrc_w = 1'b0;
      LSEL_ONE:   lsrc_w = 1'b1;
      default:    lsrc_w = 1'b0;
    endcase
  end

  assign pre_w = {lsrc_w ^ cout_w, sum_w};

  alu_rotator #(.N(N)) u_rot (
    .d_i(pre_w), .rot_i(rot_i), .q_o(rot_w)
  );

  always_ff @(posedge clk) begin
    if (rst) res_o <= '0;
    else     res_o <= rot_w;
  end

  // Reference sum used only by the assertions below.
  logic [W:0] ref_sum_w;
  assign ref_sum_w = {1'b0, a_w} + {1'b0, b_w};

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> res_o == '0);

  p_sum_ref_r4: assert property (@(posedge clk) disable iff (rst)
    (rot_i == '0) |=> res_o == {$past(lsrc_w ^ ref_sum_w[W]), $past(ref_sum_w[W-1:0])});

  p_rotl1_r6: assert property (@(posedge clk) disable iff (rst)
    (rot_i == 4'b0001) |=> res_o == {$past(pre_w[N-2:0]), $past(pre_w[N-1])});

  p_rotr1_r7: assert property (@(posedge clk) disable iff (rst)
    (rot_i == 4'b0100) |=> res_o == {$past(pre_w[0]), $past(pre_w[N-1:1])});

  p_multi_pass_r9: assert property (@(posedge clk) disable iff (rst)
    ($countones(rot_i) > 1) |=> res_o == $past(pre_w));
endmodule

// File: tb/tb_alu_link_rot.sv
module tb_alu_link_rot;
  localparam int W = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  bus_i = '0, acc_i = '0;
  logic          link_i = 1'b0;
  logic [1:0]    asel_i = '0, bsel_i = '0, lsel_i = '0;
  logic [3:0]    rot_i = '0;
  logic [W:0]    res_o;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [W:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  alu_link_rot #(.W(W)) dut (
    .clk(clk), .rst(rst), .bus_i(bus_i), .acc_i(acc_i), .link_i(link_i),
    .asel_i(asel_i), .bsel_i(bsel_i), .lsel_i(lsel_i), .rot_i(rot_i), .res_o(res_o)
  );

  function automatic logic [W:0] model(logic [W-1:0] bus, logic [W-1:0] acc, logic lnk,
                                       logic [1:0] as, logic [1:0] bs, logic [1:0] ls,
                                       logic [3:0] rot);
    logic [W-1:0] a, b;
    logic [W:0]   s, w;
    logic         l;
    case (as)
      2'd0: a = bus;
      2'd1: a = '0;
      2'd2: a = bus & acc;
      default: a = bus | acc;
    endcase
    case (bs)
      2'd0: b = acc;
      2'd1: b = ~acc;
      2'd2: b = '0;
      default: b = '1;
    endcase
    case (ls)
      2'd0: l = lnk;
      2'd1: l = ~lnk;
      2'd2: l = 1'b0;
      default: l = 1'b1;
    endcase
    s = {1'b0, a} + {1'b0, b};
    w = {l ^ s[W], s[W-1:0]};
    case (rot)
      4'b0001: return {w[W-1:0], w[W]};
      4'b0010: return {w[W-2:0], w[W:W-1]};
      4'b0100: return {w[0], w[W:1]};
      4'b1000: return {w[1:0], w[W:2]};
      default: return w;
    endcase
  endfunction

  task automatic drv(logic [W-1:0] bus, logic [W-1:0] acc, logic lnk, logic [1:0] as,
                     logic [1:0] bs, logic [1:0] ls, logic [3:0] rot, string tag);
    item_t it;
    @(negedge clk);
    bus_i = bus; acc_i = acc; link_i = lnk;
    asel_i = as; bsel_i = bs; lsel_i = ls; rot_i = rot;
    it.exp = model(bus, acc, lnk, as, bs, ls, rot);
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: result of the previous negedge drive appears after the next rising edge (R10).
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_cmp++;
        if (res_o !== it.exp) begin
          n_bad++;
          $display("FAIL %s: got %o expected %o", it.tag, res_o, it.exp);
        end
      end
    end
  end

  task automatic chk_reset(string tag);
    @(posedge clk);
    #1;
    n_cmp++;
    if (res_o !== '0) begin
      n_bad++;
      $display("FAIL %s: got %o expected 0", tag, res_o);
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bus_i = 12'o5252; acc_i = 12'o7070; rot_i = 4'b0001; lsel_i = 2'd3;
    repeat (3) @(negedge clk);
    chk_reset("R1 initial reset");
    @(negedge clk);
    rst = 1'b0;

    // R2: operand A codes with B zero
    for (int s = 0; s < 4; s++) drv(12'o5314, 12'o3672, 1'b0, s[1:0], 2'd2, 2'd2, 4'b0000, "R2 asel");
    // R3: operand B codes with A zero
    for (int s = 0; s < 4; s++) drv(12'o1234, 12'o6041, 1'b0, 2'd1, s[1:0], 2'd2, 4'b0000, "R3 bsel");
    // R4: carry boundaries and random sums
    drv(12'o7777, 12'o0001, 1'b0, 2'd0, 2'd0, 2'd0, 4'b0000, "R4 overflow 7777+1");
    drv(12'o7776, 12'o0001, 1'b0, 2'd0, 2'd0, 2'd0, 4'b0000, "R4 no carry 7776+1");
    drv(12'o4000, 12'o4000, 1'b0, 2'd0, 2'd0, 2'd0, 4'b0000, "R4 top carry");
    drv(12'o0001, 12'o0000, 1'b0, 2'd0, 2'd3, 2'd0, 4'b0000, "R4 plus ones wraps");
    for (int k = 0; k < 40; k++)
      drv(W'($urandom), W'($urandom), 1'($urandom), 2'd0, 2'd0, 2'd0, 4'b0000, "R4 random sum");
    // R5: link codes with and without carry
    for (int s = 0; s < 4; s++) begin
      drv(12'o7777, 12'o0001, 1'b0, 2'd0, 2'd0, s[1:0], 4'b0000, "R5 link with carry");
      drv(12'o0003, 12'o0001, 1'b1, 2'd0, 2'd0, s[1:0], 4'b0000, "R5 link no carry");
    end
    // R6 / R7: rotations of asymmetric patterns
    drv(12'o4001, 12'o0000, 1'b1, 2'd0, 2'd2, 2'd0, 4'b0001, "R6 rotate left 1");
    drv(12'o4001, 12'o0000, 1'b1, 2'd0, 2'd2, 2'd0, 4'b0010, "R6 rotate left 2");
    drv(12'o6000, 12'o0000, 1'b0, 2'd0, 2'd2, 2'd0, 4'b0010, "R6 left 2 wrap");
    drv(12'o0003, 12'o0000, 1'b0, 2'd0, 2'd2, 2'd0, 4'b0100, "R7 rotate right 1");
    drv(12'o0003, 12'o0000, 1'b0, 2'd0, 2'd2, 2'd0, 4'b1000, "R7 rotate right 2");
    drv(12'o0001, 12'o0000, 1'b1, 2'd0, 2'd2, 2'd0, 4'b1000, "R7 right 2 wrap");
    for (int k = 0; k < 20; k++)
      drv(W'($urandom), W'($urandom), 1'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
          4'(1 << (k % 4)), "R6 R7 random rotate");
    // R8: no select passes through
    drv(12'o1357, 12'o0000, 1'b1, 2'd0, 2'd2, 2'd0, 4'b0000, "R8 pass through");
    // R9: multiple selects pass through
    drv(12'o4001, 12'o0000, 1'b1, 2'd0, 2'd2, 2'd0, 4'b0011, "R9 two lefts");
    drv(12'o4001, 12'o0000, 1'b0, 2'd0, 2'd2, 2'd0, 4'b0101, "R9 left and right");
    drv(12'o2461, 12'o0000, 1'b1, 2'd0, 2'd2, 2'd0, 4'b1111, "R9 all selects");
    // R10: back-to-back changes each land one cycle later
    drv(12'o0000, 12'o0000, 1'b0, 2'd1, 2'd3, 2'd3, 4'b0000, "R10 latency a");
    drv(12'o1111, 12'o2222, 1'b0, 2'd0, 2'd0, 2'd2, 4'b0000, "R10 latency b");

    // R1: reset mid-run with active inputs
    @(negedge clk);
    rst = 1'b1; bus_i = 12'o7777; acc_i = 12'o7777; rot_i = 4'b0100;
    chk_reset("R1 reset mid-run");
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule